// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the bus-facing slave of a byte-addressed serial EEPROM. It watches the two I2C lines, recognises START and STOP, and after each START accepts a control byte. That byte carries a fixed device-type nibble, three address bits that must match the strap inputs, and a read/write flag. A write carries two word-address bytes and then data bytes. A read returns bytes from an internal pointer. The only drive onto SDA is a pull-low enable, which the pad turns into an open-drain output.

Written bytes gather in a one-page buffer. They reach the array only when a STOP closes the transaction. The array is a register array whose address width is a parameter, and every location holds 0xFF after reset. A write-protect input blocks all array updates. Under write protect the control byte and the address bytes are still acknowledged, but data bytes are not.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The block answers nothing on the bus until a START has been seen. A STOP returns it to idle.
- R2: After a START the first byte is a control byte. Bits 7:4 must be 1010 and bits 3:1 must equal `dev_strap_i[2:0]`. On a mismatch the block gives no acknowledge and ignores the bus until the next START, so no array location changes.
- R3: Each accepted byte is acknowledged by asserting `sda_pull_o` during the ninth SCL pulse. The pull only changes after an SCL falling edge, or is released at START or STOP.
- R4: Bit 0 of the control byte selects the operation: 0 is a write and 1 is a read. A write sends the address high byte first, then the low byte, then data bytes. Address bits at and above MEM_AW are ignored (default MEM_AW=9, 512 bytes). Data is written to the array when the STOP arrives.
- R5: During a write burst the low 6 address bits count up and wrap inside the current 64-byte page, and the upper bits stay fixed.
- R6: While `wp_i` is high, the control byte and both address bytes are acknowledged, data bytes are not acknowledged, and the array is left unchanged.
- R7: A read sends the byte at the pointer MSB first and then increments the pointer across the whole array, wrapping from the top to 0. A control byte with bit 0 set and no preceding address reads from the current pointer.
- R8: If the master acknowledges a read byte, the next byte follows. If it does not, the block releases SDA and stays silent until the next START.
- R9: A repeated START after the two address bytes, followed by a read control byte, reads from the address just sent.
- R10: After reset every array location reads 0xFF.
- R11: Data bytes that have not yet been committed are discarded by a START that comes before any STOP.
- R12: During and after reset `sda_pull_o` is low, so the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_strap_i | input | 3 | Device select straps compared with control bits 3:1 |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA pad |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except at START and STOP. Each line level is held for several system clocks, longer than the synchronizer delay. Write protect is steady for the whole of a transaction. The bench meets these conditions by holding every quarter of an SCL period for six system clocks, driving SDA only in the low half, and changing `wp_i` only between a STOP and the next START.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int PAGE_AW = 6;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [1:0] {
        LINK_IDLE,
        LINK_RX,
        LINK_TX
    } link_state_e;

    typedef enum logic [1:0] {
        RX_CTRL,
        RX_ADDR_HI,
        RX_ADDR_LO,
        RX_DATA
    } rx_phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic ctrl_selects(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import eeprom_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_comb begin
        evt_o.scl_rise = scl_s & ~scl_d;
        evt_o.scl_fall = ~scl_s & scl_d;
        evt_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt_o.sda      = sda_s;
    end

endmodule

// File: rtl/eeprom_xfer_engine.sv
module eeprom_xfer_engine
    import eeprom_i2c_pkg::*;
#(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [2:0]        strap,
    input  logic              wp,
    input  logic [7:0]        rd_data,
    output logic [MEM_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic              discard,
    output logic              sda_pull
);

    link_state_e       state;
    rx_phase_e         phase;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        addr_hi;
    logic [MEM_AW-1:0] ptr;
    logic              rd_next;
    logic              master_ack;
    logic              pull;
    logic [15:0]       addr16;

    assign addr16   = {addr_hi, shreg};
    assign rd_addr  = ptr;
    assign wr_addr  = ptr;
    assign wr_data  = shreg;
    assign commit   = evt.stop;
    assign discard  = evt.start;
    assign sda_pull = pull;

    always_comb begin
        wr_en = (state == LINK_RX) && (phase == RX_DATA) && evt.scl_fall
                && (bitcnt == 4'd8) && !wp;
    end

    function automatic logic [MEM_AW-1:0] page_inc(input logic [MEM_AW-1:0] a);
        logic [MEM_AW-1:0] r;
        r = a;
        r[PAGE_AW-1:0] = a[PAGE_AW-1:0] + 1'b1;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LINK_IDLE;
            phase      <= RX_CTRL;
            bitcnt     <= '0;
            shreg      <= '0;
            addr_hi    <= '0;
            ptr        <= '0;
            rd_next    <= 1'b0;
            master_ack <= 1'b0;
            pull       <= 1'b0;
        end else if (evt.stop) begin
            state  <= LINK_IDLE;
            pull   <= 1'b0;
            bitcnt <= '0;
        end else if (evt.start) begin
            state  <= LINK_RX;
            phase  <= RX_CTRL;
            bitcnt <= '0;
            pull   <= 1'b0;
        end else begin
            unique case (state)
                LINK_IDLE: ;
                LINK_RX: begin
                    if (evt.scl_rise) begin
                        if (bitcnt < 4'd8)
                            shreg <= {shreg[6:0], evt.sda};
                        if (bitcnt < 4'd9)
                            bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            unique case (phase)
                                RX_CTRL: begin
                                    if (ctrl_selects(shreg, strap)) begin
                                        pull    <= 1'b1;
                                        rd_next <= shreg[0];
                                    end else begin
                                        state <= LINK_IDLE;
                                    end
                                end
                                RX_ADDR_HI: begin
                                    pull    <= 1'b1;
                                    addr_hi <= shreg;
                                end
                                RX_ADDR_LO: begin
                                    pull <= 1'b1;
                                    ptr  <= addr16[MEM_AW-1:0];
                                end
                                RX_DATA: begin
                                    if (!wp) begin
                                        pull <= 1'b1;
                                        ptr  <= page_inc(ptr);
                                    end
                                end
                            endcase
                        end else if (bitcnt == 4'd9) begin
                            pull   <= 1'b0;
                            bitcnt <= '0;
                            unique case (phase)
                                RX_CTRL: begin
                                    if (rd_next) begin
                                        state <= LINK_TX;
                                        shreg <= rd_data;
                                        ptr   <= ptr + 1'b1;
                                        pull  <= ~rd_data[7];
                                    end else begin
                                        phase <= RX_ADDR_HI;
                                    end
                                end
                                RX_ADDR_HI: phase <= RX_ADDR_LO;
                                RX_ADDR_LO: phase <= RX_DATA;
                                RX_DATA:    phase <= RX_DATA;
                            endcase
                        end
                    end
                end
                LINK_TX: begin
                    if (evt.scl_rise) begin
                        if (bitcnt == 4'd8)
                            master_ack <= ~evt.sda;
                        if (bitcnt < 4'd9)
                            bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            shreg <= {shreg[6:0], 1'b0};
                            pull  <= ~shreg[6];
                        end else if (bitcnt == 4'd8) begin
                            pull <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (master_ack) begin
                                shreg <= rd_data;
                                ptr   <= ptr + 1'b1;
                                pull  <= ~rd_data[7];
                            end else begin
                                state <= LINK_IDLE;
                                pull  <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= LINK_IDLE;
            endcase
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_IDLE) |-> !pull); // R8

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (pull && !$past(pull)) |-> $past(evt.scl_fall)); // R3

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= 4'd9); // R3

    AST_WP_DATA_NACK: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_RX && phase == RX_DATA && bitcnt == 4'd9 && wp) |-> !pull); // R6

endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store
    import eeprom_i2c_pkg::*;
#(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic              discard,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH      = 1 << MEM_AW;
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PG_W       = MEM_AW - PAGE_AW;

    typedef logic [PAGE_AW-1:0] slot_t;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [PG_W-1:0]       page_q;
    slot_t                 wr_slot;

    assign wr_slot = wr_addr[PAGE_AW-1:0];
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
            for (int i = 0; i < PAGE_BYTES; i++)
                pbuf[i] <= 8'h00;
            pvalid <= '0;
            page_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pvalid[i])
                    mem[{page_q, slot_t'(i)}] <= pbuf[i];
            pvalid <= '0;
        end else if (discard) begin
            pvalid <= '0;
        end else if (wr_en) begin
            pbuf[wr_slot]   <= wr_data;
            pvalid[wr_slot] <= 1'b1;
            page_q          <= wr_addr[MEM_AW-1:PAGE_AW];
        end
    end

    AST_BURST_ONE_PAGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !commit && !discard && (|pvalid)) |-> (wr_addr[MEM_AW-1:PAGE_AW] == page_q)); // R5

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int MEM_AW      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);

    bus_evt_t          evt;
    logic [MEM_AW-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;
    logic              wr_en, commit, discard;

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    eeprom_xfer_engine #(.MEM_AW(MEM_AW)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .strap    (dev_strap_i),
        .wp       (wp_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (commit),
        .discard  (discard),
        .sda_pull (sda_pull_o)
    );

    eeprom_page_store #(.MEM_AW(MEM_AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .discard (discard),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        $past(rst) |-> !sda_pull_o); // R12

endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;

    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = 8'hAA;
    localparam logic [7:0] CR = 8'hAB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic bus_sda;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign bus_sda = m_sda & ~sda_pull;

    eeprom_i2c_slave u0 (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (bus_sda),
        .dev_strap_i (STRAP),
        .wp_i        (wp),
        .sda_pull_o  (sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_clock(input logic b, output logic seen);
        m_sda = b;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        seen = bus_sda;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clock(b[i], s);
        bit_clock(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clock(1'b1, s);
            b[i] = s;
        end
        bit_clock(~give_ack, s);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic [31:0] dw,
                            input logic data_ack_exp, input string tag);
        logic ack;
        i2c_start();
        send_byte(CW, ack);          chk({tag, " ctrl ack"}, ack, 1);
        send_byte(a[15:8], ack);     chk({tag, " addr hi ack"}, ack, 1);
        send_byte(a[7:0], ack);      chk({tag, " addr lo ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(dw[31-8*i -: 8], ack);
            chk({tag, " data ack"}, ack, data_ack_exp);
        end
        i2c_stop();
    endtask

    task automatic rand_read(input logic [15:0] a, input int n, output logic [31:0] dr);
        logic ack;
        logic [7:0] b;
        dr = '0;
        i2c_start();
        send_byte(CW, ack);          chk("R9 ctrl write ack", ack, 1);
        send_byte(a[15:8], ack);     chk("R9 addr hi ack", ack, 1);
        send_byte(a[7:0], ack);      chk("R9 addr lo ack", ack, 1);
        i2c_start();
        send_byte(CR, ack);          chk("R9 ctrl read ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            dr[31-8*i -: 8] = b;
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        chk("R12 pull low after reset", sda_pull, 0);
        chk("R12 bus released after reset", bus_sda, 1);
    endtask

    task automatic t_erased();
        logic [31:0] d;
        rand_read(16'h0010, 1, d);
        chk("R10 erased byte", d[31:24], 8'hFF);
    endtask

    task automatic t_byte_write();
        logic [31:0] d;
        do_write(16'h0012, 1, 32'h1E000000, 1'b1, "R4 byte write");
        rand_read(16'h0012, 1, d);
        chk("R4 byte write readback MSB first", d[31:24], 8'h1E);
        do_write(16'hFE34, 1, 32'h3C000000, 1'b1, "R4 high bits");
        rand_read(16'h0034, 1, d);
        chk("R4 high address bits ignored", d[31:24], 8'h3C);
        rand_read(16'h0134, 1, d);
        chk("R4 neighbour page untouched", d[31:24], 8'hFF);
    endtask

    task automatic t_mismatch();
        logic ack;
        logic [31:0] d;
        i2c_start();
        send_byte(8'hA6, ack);  chk("R2 wrong strap no ack", ack, 0);
        send_byte(8'h00, ack);  chk("R2 ignored after mismatch", ack, 0);
        send_byte(8'h50, ack);  chk("R2 ignored addr lo", ack, 0);
        send_byte(8'h99, ack);  chk("R2 ignored data", ack, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'hBA, ack);  chk("R2 wrong type no ack", ack, 0);
        i2c_stop();
        rand_read(16'h0050, 1, d);
        chk("R2 array untouched", d[31:24], 8'hFF);
    endtask

    task automatic t_no_start();
        logic ack;
        send_byte(CW, ack);
        chk("R1 no answer without START", ack, 0);
        chk("R1 line released while idle", sda_pull, 0);
        i2c_stop();
    endtask

    task automatic t_page_wrap();
        logic [31:0] d;
        do_write(16'h007E, 4, 32'h11223344, 1'b1, "R5 page burst");
        rand_read(16'h007E, 3, d);
        chk("R5 byte at 0x7E", d[31:24], 8'h11);
        chk("R8 sequential byte at 0x7F", d[23:16], 8'h22);
        chk("R7 read crosses page to 0x80", d[15:8], 8'hFF);
        rand_read(16'h0040, 2, d);
        chk("R5 wrapped byte at 0x40", d[31:24], 8'h33);
        chk("R5 wrapped byte at 0x41", d[23:16], 8'h44);
    endtask

    task automatic t_wp();
        logic [31:0] d;
        wp = 1'b1;
        do_write(16'h0012, 1, 32'h77000000, 1'b0, "R6 protected");
        wp = 1'b0;
        rand_read(16'h0012, 1, d);
        chk("R6 array unchanged", d[31:24], 8'h1E);
    endtask

    task automatic t_current_read();
        logic ack;
        logic [7:0] b;
        logic [31:0] d;
        do_write(16'h0100, 3, 32'h5A6B7700, 1'b1, "R7 setup");
        rand_read(16'h0100, 1, d);
        chk("R7 random byte", d[31:24], 8'h5A);
        i2c_start();
        send_byte(CR, ack);  chk("R7 current read ctrl ack", ack, 1);
        recv_byte(1'b0, b);
        chk("R7 current address byte", b, 8'h6B);
        tick(Q);
        chk("R8 released after master nack", sda_pull, 0);
        send_byte(8'h00, ack);
        chk("R8 silent after nack", ack, 0);
        i2c_stop();
    endtask

    task automatic t_top_wrap();
        logic [31:0] d;
        do_write(16'h01FF, 1, 32'hE1000000, 1'b1, "R7 top");
        do_write(16'h0000, 1, 32'h0E000000, 1'b1, "R7 bottom");
        rand_read(16'h01FF, 2, d);
        chk("R7 top byte", d[31:24], 8'hE1);
        chk("R7 pointer wraps to 0", d[23:16], 8'h0E);
    endtask

    task automatic t_discard();
        logic ack;
        logic [7:0] b;
        logic [31:0] d;
        i2c_start();
        send_byte(CW, ack);     chk("R11 ctrl ack", ack, 1);
        send_byte(8'h00, ack);  chk("R11 addr hi ack", ack, 1);
        send_byte(8'h20, ack);  chk("R11 addr lo ack", ack, 1);
        send_byte(8'h99, ack);  chk("R11 data ack", ack, 1);
        i2c_start();
        send_byte(CR, ack);     chk("R9 read after repeated START", ack, 1);
        recv_byte(1'b0, b);
        chk("R11 byte at 0x21", b, 8'hFF);
        i2c_stop();
        rand_read(16'h0020, 1, d);
        chk("R11 uncommitted data dropped", d[31:24], 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        t_reset();
        rst = 1'b0;
        tick(5);
        t_reset();
        t_erased();
        t_byte_write();
        t_mismatch();
        t_no_start();
        t_page_wrap();
        t_wp();
        t_current_read();
        t_top_wrap();
        t_discard();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule